// File: doc/BRIEF.md
# Triggered Clock Glitch Inserter

This block produces the clock for a processor under fault-injection study. Its output normally tracks a clean base clock. When armed and then triggered by the core, it inserts exactly one shortened pulse into that clock. The core raises the trigger when it recognises the instruction chosen as the target.

The position and the length of the extra pulse are not timed by logic inside the block. Two auxiliary clocks come from an external generator. Both are phase-shifted copies of the base clock. The phase of the first copy sets where the pulse starts, and the phase of the second copy sets where it ends. The pulse is high while the first copy is high and the second is still low. The logic only chooses which base cycle carries the pulse. It does this by counting a programmed number of whole cycles after the trigger. The result is a rising edge that arrives early, so one clock period is shorter than nominal.

Each arm command allows one glitch and no more. A done flag then stays up until software arms the block again.

Top module: `glitch_inserter`

## Requirements
- R1: After reset, `done_o` is 0, no glitch is pending, and `clk_out` equals `clk_base` with no extra rising edges.
- R2: An `arm_i` pulse sampled while idle or done captures `delay_i` and readies the block. In the done state, the same arm also drops `done_o` at that edge.
- R3: While armed, a `trig_i` sampled high at base edge E0 places the glitch in the base cycle that begins at edge E0 plus the captured delay. A delay of 0 puts the glitch in the cycle that begins at E0.
- R4: In the glitch cycle, `clk_out` is `clk_base` OR (`clk_ofs` AND NOT `clk_wid`). This produces exactly one extra rising edge inside the low half of that base cycle.
- R5: Outside the glitch cycle, `clk_out` equals `clk_base` and carries no extra rising edges.
- R6: `done_o` rises at the base edge that ends the glitch cycle. It stays high until the next accepted arm.
- R7: A trigger sampled while idle or done causes no glitch.
- R8: An arm pulse sampled while armed or counting the delay is ignored. The delay captured earlier still sets the glitch cycle.
- R9: The largest delay of 255 cycles places the glitch 255 cycles after E0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Clean base clock; also clocks the control logic |
| clk_ofs | input | 1 | Phase-shifted copy whose rising edge starts the glitch pulse |
| clk_wid | input | 1 | Phase-shifted copy whose rising edge ends the glitch pulse |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm command, sampled on the base clock |
| delay_i | input | DLY_W | Cycle delay between trigger and glitch, captured at arm |
| trig_i | input | 1 | Trigger from the core |
| clk_out | output | 1 | Processor clock carrying at most one glitch per arm |
| done_o | output | 1 | Glitch has been emitted since the last arm |

## Verification
The bench builds the block with the default delay width of 8 bits. This brings both the zero-delay case and the full 255-cycle delay within reach in one short run.

The auxiliary clocks are placed so that the pulse falls 5 ns into each base period. It ends 1 ns later, inside the low half of the base clock. Every extra rising edge on the output can therefore be told apart from a base edge and tied to a specific cycle number.

// File: rtl/glitch_pkg.sv
package glitch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_DELAY  = 3'd2,
        ST_GLITCH = 3'd3,
        ST_DONE   = 3'd4
    } gl_state_e;
endpackage

// File: rtl/glitch_ctrl.sv
module glitch_ctrl
    import glitch_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             trig_i,
    output logic             glitch_en_o,
    output logic             done_o
);
    localparam logic [DLY_W-1:0] ZERO = '0;

    typedef struct packed {
        gl_state_e        st;
        logic [DLY_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (arm_i) begin
                    r_d.st  = ST_ARMED;
                    r_d.dly = delay_i;
                end
            end
            ST_ARMED: begin
                if (trig_i) begin
                    if (r_q.dly == ZERO) begin
                        r_d.st = ST_GLITCH;
                    end else begin
                        r_d.st  = ST_DELAY;
                        r_d.cnt = r_q.dly - 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (r_q.cnt == ZERO) r_d.st = ST_GLITCH;
                else                 r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_GLITCH: r_d.st = ST_DONE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: ZERO, dly: ZERO};
        end else begin
            r_q <= r_d;
        end
    end

    assign glitch_en_o = (r_q.st == ST_GLITCH);
    assign done_o      = (r_q.st == ST_DONE);

    // R5/R6: the single glitch cycle is always followed by the done state
    assert_single_glitch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_en_o |=> (done_o && !glitch_en_o));

    // R7: a trigger while done, without a new arm, never yields a glitch
    assert_trig_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> (done_o && !glitch_en_o));

    // R2: an accepted arm drops the done flag
    assert_arm_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && arm_i) |=> (!done_o && r_q.st == ST_ARMED));

    // R3: while the delay counter is nonzero, the glitch cannot begin
    assert_delay_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DELAY && r_q.cnt != ZERO) |=> (r_q.st == ST_DELAY));

    // R8: the captured delay is stable while armed or counting
    assert_rearm_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED || r_q.st == ST_DELAY) |=> $stable(r_q.dly));
endmodule

// File: rtl/glitch_clk_mux.sv
module glitch_clk_mux (
    input  logic clk_base,
    input  logic clk_ofs,
    input  logic clk_wid,
    input  logic glitch_en,
    output logic clk_out
);
    logic pulse;

    // pulse is high from the rising edge of clk_ofs to the rising edge of clk_wid
    assign pulse   = clk_ofs & ~clk_wid;
    // glitch_en changes just after a base rising edge, while clk_base is high,
    // so the OR leaves the output free of hazards
    assign clk_out = clk_base | (glitch_en & pulse);
endmodule

// File: rtl/glitch_inserter.sv
module glitch_inserter #(
    parameter int DLY_W = 8
) (
    input  logic             clk_base,
    input  logic             clk_ofs,
    input  logic             clk_wid,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             trig_i,
    output logic             clk_out,
    output logic             done_o
);
    logic glitch_en;

    glitch_ctrl #(.DLY_W(DLY_W)) ctrl_i (
        .clk         (clk_base),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .delay_i     (delay_i),
        .trig_i      (trig_i),
        .glitch_en_o (glitch_en),
        .done_o      (done_o)
    );

    glitch_clk_mux mux_i (
        .clk_base  (clk_base),
        .clk_ofs   (clk_ofs),
        .clk_wid   (clk_wid),
        .glitch_en (glitch_en),
        .clk_out   (clk_out)
    );
endmodule

// File: tb/glitch_inserter_tb_top.sv
module glitch_inserter_tb_top;
    localparam int DLY_W = 8;

    logic clk_base = 1'b0;
    logic clk_ofs  = 1'b0;
    logic clk_wid  = 1'b0;
    logic rst_n    = 1'b0;
    logic arm_i    = 1'b0;
    logic trig_i   = 1'b0;
    logic [DLY_W-1:0] delay_i = '0;
    logic clk_out, done_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int extra_edges = 0;
    int exp_q[$];

    glitch_inserter #(.DLY_W(DLY_W)) dut_i (
        .clk_base (clk_base),
        .clk_ofs  (clk_ofs),
        .clk_wid  (clk_wid),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .delay_i  (delay_i),
        .trig_i   (trig_i),
        .clk_out  (clk_out),
        .done_o   (done_o)
    );

    // 125 MHz base clock: high from 4 ns to 8 ns of each 8 ns slot
    initial begin #4; forever begin clk_base = 1'b1; #4; clk_base = 1'b0; #4; end end
    // pulse window: the offset copy rises 5 ns after base, the width copy 6 ns after
    initial begin #9;  forever begin clk_ofs = 1'b1; #4; clk_ofs = 1'b0; #4; end end
    initial begin #10; forever begin clk_wid = 1'b1; #4; clk_wid = 1'b0; #4; end end

    always @(posedge clk_base) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: any output rising edge while base is low is a glitch edge
    always @(posedge clk_out) begin
        if (clk_base == 1'b0) begin
            extra_edges++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R7 unexpected glitch cycle", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R3/R4 glitch cycle", cyc, e);
            end
        end
    end

    task automatic do_arm(input int d);
        @(negedge clk_base);
        arm_i = 1'b1; delay_i = DLY_W'(d);
        @(negedge clk_base);
        arm_i = 1'b0;
    endtask

    task automatic fire(input bit expect_glitch, input int d);
        @(negedge clk_base);
        trig_i = 1'b1;
        if (expect_glitch) exp_q.push_back(cyc + 1 + d);
        @(negedge clk_base);
        trig_i = 1'b0;
    endtask

    task automatic run_glitch(input int d, input string req);
        fire(1'b1, d);
        repeat (d + 2) @(negedge clk_base);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(done_o == 1'b1, "R6 done after glitch", done_o, 1);
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk_base);
        // R1: reset state
        check(done_o == 1'b0, "R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_base);
        check(done_o == 1'b0 && extra_edges == 0, "R1 idle after reset", extra_edges, 0);

        // R7: trigger while idle is ignored
        fire(1'b0, 0);
        repeat (4) @(negedge clk_base);
        check(extra_edges == 0 && done_o == 1'b0, "R7 trigger in idle", extra_edges, 0);

        // R2/R3/R4: zero delay
        do_arm(0);
        check(done_o == 1'b0, "R2 armed, not done", done_o, 0);
        repeat (3) @(negedge clk_base);
        check(extra_edges == 0, "R5 no glitch while armed", extra_edges, 0);
        run_glitch(0, "R3 delay 0 glitch seen");
        check(extra_edges == 1, "R4 one extra edge", extra_edges, 1);

        // R7: trigger while done is ignored; R6 done holds
        snap = extra_edges;
        fire(1'b0, 0);
        repeat (5) @(negedge clk_base);
        check(extra_edges == snap, "R7 trigger in done", extra_edges, snap);
        check(done_o == 1'b1, "R6 done holds", done_o, 1);

        // R2: arm clears done; delay 5
        do_arm(5);
        check(done_o == 1'b0, "R2 arm clears done", done_o, 0);
        run_glitch(5, "R3 delay 5 glitch seen");

        // R8: re-arm while armed and while delaying is ignored
        do_arm(3);
        do_arm(0);
        fire(1'b1, 3);
        arm_i = 1'b1; delay_i = '0;
        @(negedge clk_base);
        arm_i = 1'b0;
        repeat (4) @(negedge clk_base);
        check(exp_q.size() == 0, "R8 captured delay kept", exp_q.size(), 0);
        check(done_o == 1'b1, "R8 done after kept delay", done_o, 1);

        // R9: largest delay
        do_arm(255);
        run_glitch(255, "R9 delay 255 glitch seen");

        snap = extra_edges;
        repeat (6) @(negedge clk_base);
        check(extra_edges == snap, "R5 quiet after glitch", extra_edges, snap);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule